// File: doc/BRIEF.md
# Raster Timer Interrupt Unit

This block is a programmable down-counter that raises an interrupt request for a video controller. Software writes 16-bit words into a small register window. The window holds a mode word, a 32-bit reload value split into an upper and a lower half, an acknowledge word and a border-stop control. The counter steps down once on every cycle in which the pixel tick input is high. When a step finds the counter at zero, the timer expires. An expiry can raise the timer pending flag and can reload the counter.

Three interrupt sources share one request line: the frame-blank event, the timer, and a third auxiliary source. Each source has a sticky pending flag, and software clears each flag with its own bit in the acknowledge word. In 50 Hz (PAL) operation, software can make the counter pause on the 16 lines at the top of the frame and the 16 lines at the bottom. A status word reports the current line number and the 50/60 Hz setting.

Top module: `rastTimerIrq`

## Requirements
- R1: After reset, `pendFlags` is 0 and `irqOut` is low.
- R2: A write to word index 1 stores the upper reload half and a write to word index 2 stores the lower half. When mode bit 5 is set, a write to index 2 loads the counter with {upper half, written word}. A loaded value N first raises the timer flag on the N+1-th counting tick.
- R3: The counter drops by one on each cycle in which `pixTick` is high and counting is not paused. A counting tick that finds the counter at zero is an expiry.
- R4: An expiry raises the timer pending flag (`pendFlags[1]`) only when mode bit 4 is set. With bit 4 clear, the counter keeps counting and reloading.
- R5: With mode bit 7 set, an expiry reloads the counter from the stored reload value. With bit 7 clear, the counter wraps from zero to all ones.
- R6: A `vblankEvt` pulse sets `pendFlags[2]`, and also reloads the counter from the stored reload value when mode bit 6 is set. Writing the lower half with bit 5 clear does not load the counter.
- R7: A write to word index 3 clears `pendFlags[2]`, `[1]` and `[0]` where data bits 2, 1 and 0 are set. Other data bits have no effect. A source event in the same cycle as its acknowledge leaves the flag set.
- R8: When bit 0 of word index 4 is set and `palMode` is high, counting pauses on lines 0..15 and on lines FRAME_LINES-16 and above (296..311 by default). Line 16 and line 295 still count.
- R9: `irqOut` is high exactly when at least one pending flag is set.
- R10: `statusWord` carries `lineNum` in bits 15:7 and `palMode` in bit 3 (1 = 50 Hz), with all other bits 0.
- R11: A `auxEvt` pulse sets `pendFlags[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe, one word per cycle |
| regAddr | input | 3 | Word index of the register being written |
| regWdata | input | 16 | Write data |
| pixTick | input | 1 | Count enable from the pixel clock divider |
| lineNum | input | 9 | Current raster line |
| palMode | input | 1 | High for 50 Hz timing |
| vblankEvt | input | 1 | One-cycle frame-blank event |
| auxEvt | input | 1 | One-cycle event from the third source |
| irqOut | output | 1 | Interrupt request |
| pendFlags | output | 3 | Pending flags: [2] blank, [1] timer, [0] aux |
| statusWord | output | 16 | Line number and 50/60 Hz indicator |

## Verification
The assertions assume that `vblankEvt` and `auxEvt` are single-cycle pulses, that `regWe` carries at most one word per cycle, and that `lineNum` stays below the frame length. The bench changes inputs only on falling edges. It holds `pixTick` for an exact number of cycles and never loads the counter in the same cycle as a counting tick. This keeps every expiry at a count that can be worked out from the reload value.

// File: rtl/rastTimerPkg.sv
package rastTimerPkg;

  typedef enum logic [2:0] {
    ADDR_MODE   = 3'd0,
    ADDR_RLD_HI = 3'd1,
    ADDR_RLD_LO = 3'd2,
    ADDR_ACK    = 3'd3,
    ADDR_STOP   = 3'd4
  } regAddrE;

  localparam int MODE_LO      = 4;
  localparam int MODE_EN_BIT  = 4;
  localparam int MODE_LDW_BIT = 5;
  localparam int MODE_LDV_BIT = 6;
  localparam int MODE_RPT_BIT = 7;
  localparam int MODE_BITS    = 4;

  localparam int NUM_SRC  = 3;
  localparam int PEND_AUX = 0;
  localparam int PEND_TMR = 1;
  localparam int PEND_VBL = 2;

  localparam int PAL_FLAG_BIT = 3;

  typedef struct packed {
    logic load;
    logic countEn;
    logic reloadOnZero;
  } cntStrobeT;

endpackage

// File: rtl/rastTimerCtrl.sv
module rastTimerCtrl
  import rastTimerPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int LINE_W      = 9,
  parameter int FRAME_LINES = 312,
  parameter int EDGE_LINES  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [2:0]            regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  input  logic                  pixTick,
  input  logic [LINE_W-1:0]     lineNum,
  input  logic                  palMode,
  input  logic                  vblankEvt,
  input  logic                  auxEvt,
  input  logic                  zeroHit,
  output cntStrobeT             strobes,
  output logic [2*DATA_W-1:0]   loadValue,
  output logic [NUM_SRC-1:0]    pendFlags,
  output logic [DATA_W-1:0]     statusWord
);

  localparam logic [LINE_W-1:0] TOP_END   = LINE_W'(EDGE_LINES);
  localparam logic [LINE_W-1:0] BOT_START = LINE_W'(FRAME_LINES - EDGE_LINES);

  logic [MODE_BITS-1:0] modeBits;
  logic                 stopEn;
  logic [DATA_W-1:0]    reloadHi;
  logic [DATA_W-1:0]    reloadLo;

  logic wrMode, wrHi, wrLo, wrAck, wrStop;
  logic inBorder, pauseNow, loadOnWrite, loadOnVbl;
  logic [NUM_SRC-1:0] setVec;

  always_comb begin
    wrMode = regWe && (regAddr == ADDR_MODE);
    wrHi   = regWe && (regAddr == ADDR_RLD_HI);
    wrLo   = regWe && (regAddr == ADDR_RLD_LO);
    wrAck  = regWe && (regAddr == ADDR_ACK);
    wrStop = regWe && (regAddr == ADDR_STOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeBits <= '0;
      stopEn   <= 1'b0;
      reloadHi <= '0;
      reloadLo <= '0;
    end else begin
      if (wrMode) modeBits <= regWdata[MODE_LO +: MODE_BITS];
      if (wrStop) stopEn   <= regWdata[0];
      if (wrHi)   reloadHi <= regWdata;
      if (wrLo)   reloadLo <= regWdata;
    end
  end

  always_comb begin
    inBorder    = (lineNum < TOP_END) || (lineNum >= BOT_START);
    pauseNow    = stopEn && palMode && inBorder;
    loadOnWrite = wrLo && modeBits[MODE_LDW_BIT-MODE_LO];
    loadOnVbl   = vblankEvt && modeBits[MODE_LDV_BIT-MODE_LO];
    strobes.load         = loadOnWrite || loadOnVbl;
    strobes.countEn      = pixTick && !pauseNow;
    strobes.reloadOnZero = modeBits[MODE_RPT_BIT-MODE_LO];
    loadValue = loadOnWrite ? {reloadHi, regWdata} : {reloadHi, reloadLo};
  end

  always_comb begin
    setVec           = '0;
    setVec[PEND_AUX] = auxEvt;
    setVec[PEND_TMR] = zeroHit && modeBits[MODE_EN_BIT-MODE_LO];
    setVec[PEND_VBL] = vblankEvt;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_pend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          pendFlags[s] <= 1'b0;
      else if (setVec[s]) pendFlags[s] <= 1'b1;
      else if (wrAck && regWdata[s]) pendFlags[s] <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[DATA_W-1 -: LINE_W] = lineNum;
    statusWord[PAL_FLAG_BIT] = palMode;
  end

endmodule

// File: rtl/rastTimerDp.sv
module rastTimerDp
  import rastTimerPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobeT        strobes,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] cntVal,
  output logic             zeroHit
);

  logic atZero;

  always_comb begin
    atZero  = (cntVal == '0);
    zeroHit = strobes.countEn && !strobes.load && atZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strobes.load) begin
      cntVal <= loadValue;
    end else if (strobes.countEn) begin
      if (atZero && strobes.reloadOnZero) cntVal <= loadValue;
      else                                 cntVal <= cntVal - 1'b1;
    end
  end

endmodule

// File: rtl/rastTimerIrq.sv
module rastTimerIrq
  import rastTimerPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int LINE_W      = 9,
  parameter int FRAME_LINES = 312,
  parameter int EDGE_LINES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              pixTick,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              palMode,
  input  logic              vblankEvt,
  input  logic              auxEvt,
  output logic              irqOut,
  output logic [2:0]        pendFlags,
  output logic [DATA_W-1:0] statusWord
);

  localparam int CNT_W = 2 * DATA_W;

  cntStrobeT        strobes;
  logic [CNT_W-1:0] loadValue;
  logic [CNT_W-1:0] cntVal;
  logic             zeroHit;

  rastTimerCtrl #(
    .DATA_W(DATA_W), .LINE_W(LINE_W),
    .FRAME_LINES(FRAME_LINES), .EDGE_LINES(EDGE_LINES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .pixTick(pixTick), .lineNum(lineNum),
    .palMode(palMode), .vblankEvt(vblankEvt), .auxEvt(auxEvt),
    .zeroHit(zeroHit), .strobes(strobes), .loadValue(loadValue),
    .pendFlags(pendFlags), .statusWord(statusWord)
  );

  rastTimerDp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadValue(loadValue),
    .cntVal(cntVal), .zeroHit(zeroHit)
  );

  assign irqOut = |pendFlags;

endmodule

// File: rtl/rastTimerChk.sv
module rastTimerChk
  import rastTimerPkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWe,
  input logic [2:0]          regAddr,
  input logic [DATA_W-1:0]   regWdata,
  input logic                vblankEvt,
  input logic                irqOut,
  input logic [2:0]          pendFlags,
  input cntStrobeT           strobes,
  input logic [2*DATA_W-1:0] loadValue,
  input logic [2*DATA_W-1:0] cntVal,
  input logic                zeroHit
);

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> cntVal == $past(loadValue));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.countEn && !strobes.load) |=> $stable(cntVal));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.countEn && !strobes.load && cntVal != '0) |=> cntVal == $past(cntVal) - 1'b1);

  p_timer_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendFlags[PEND_TMR]) |-> $past(zeroHit));

  p_blank_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    vblankEvt |=> pendFlags[PEND_VBL]);

  p_aux_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pendFlags[PEND_AUX] && !(regWe && regAddr == ADDR_ACK && regWdata[PEND_AUX]))
      |=> pendFlags[PEND_AUX]);

  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(regWe && regAddr == ADDR_ACK));

endmodule

bind rastTimerIrq rastTimerChk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .vblankEvt(vblankEvt), .irqOut(irqOut),
  .pendFlags(pendFlags), .strobes(strobes), .loadValue(loadValue),
  .cntVal(cntVal), .zeroHit(zeroHit)
);

// File: tb/test_rastTimerIrq.sv
module test_rastTimerIrq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic        pixTick = 1'b0;
  logic [8:0]  lineNum = 9'd37;
  logic        palMode = 1'b1;
  logic        vblankEvt = 1'b0;
  logic        auxEvt = 1'b0;
  logic        irqOut;
  logic [2:0]  pendFlags;
  logic [15:0] statusWord;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rastTimerIrq i_rastTimerIrq (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .pixTick(pixTick), .lineNum(lineNum),
    .palMode(palMode), .vblankEvt(vblankEvt), .auxEvt(auxEvt),
    .irqOut(irqOut), .pendFlags(pendFlags), .statusWord(statusWord)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkPend(input string tag, input logic [2:0] exp);
    check(pendFlags == exp, tag, int'(pendFlags), int'(exp));
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    pixTick = 1'b1;
    repeat (n) @(negedge clk);
    pixTick = 1'b0;
  endtask

  task automatic pulseVbl();
    @(negedge clk); vblankEvt = 1'b1;
    @(negedge clk); vblankEvt = 1'b0;
  endtask

  task automatic pulseAux();
    @(negedge clk); auxEvt = 1'b1;
    @(negedge clk); auxEvt = 1'b0;
  endtask

  task automatic tReset();
    chkPend("R1 pending after reset", 3'b000);
    check(irqOut == 1'b0, "R1 irq after reset", irqOut, 0);
    check(statusWord == 16'h1288, "R10 status line37 pal", statusWord, 16'h1288);
  endtask

  task automatic tOneShot();
    palMode = 1'b0;
    wr(3'd0, 16'h0030);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0003);
    ticks(3);
    chkPend("R3 no expiry before zero", 3'b000);
    ticks(1);
    chkPend("R3 expiry on reload+1 tick", 3'b010);
    check(irqOut == 1'b1, "R9 irq with timer pending", irqOut, 1);
    wr(3'd3, 16'h0002);
    chkPend("R7 timer ack", 3'b000);
    check(irqOut == 1'b0, "R9 irq after ack", irqOut, 0);
    ticks(5);
    chkPend("R5 wrap without repeat", 3'b000);
  endtask

  task automatic tDisable();
    wr(3'd0, 16'h00A0);
    wr(3'd2, 16'h0002);
    ticks(3);
    chkPend("R4 disabled expiry silent", 3'b000);
    wr(3'd0, 16'h00B0);
    ticks(2);
    chkPend("R4 counter reloaded while disabled", 3'b000);
    ticks(1);
    chkPend("R4 counting continued while disabled", 3'b010);
    wr(3'd3, 16'h0002);
  endtask

  task automatic tRepeat();
    wr(3'd0, 16'h00B0);
    wr(3'd2, 16'h0001);
    ticks(2);
    chkPend("R5 first repeat expiry", 3'b010);
    wr(3'd3, 16'h0002);
    ticks(1);
    chkPend("R5 reloaded not yet expired", 3'b000);
    ticks(1);
    chkPend("R5 second repeat expiry", 3'b010);
    wr(3'd3, 16'h0002);
  endtask

  task automatic tBlank();
    wr(3'd0, 16'h0050);
    wr(3'd2, 16'h0005);
    pulseVbl();
    chkPend("R6 blank pending", 3'b100);
    wr(3'd3, 16'h0004);
    chkPend("R7 blank ack", 3'b000);
    ticks(5);
    chkPend("R6 reload at blank not expired", 3'b000);
    ticks(1);
    chkPend("R6 expiry after blank reload", 3'b010);
    wr(3'd3, 16'h0002);
  endtask

  task automatic tAckBits();
    pulseVbl();
    pulseAux();
    chkPend("R11 aux and blank pending", 3'b101);
    ticks(6);
    chkPend("R7 all three pending", 3'b111);
    wr(3'd3, 16'hFFF8);
    chkPend("R7 upper ack bits ignored", 3'b111);
    wr(3'd3, 16'h0004);
    chkPend("R7 ack blank only", 3'b011);
    wr(3'd3, 16'h0001);
    chkPend("R7 ack aux only", 3'b010);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'd3; regWdata = 16'h0001; auxEvt = 1'b1;
    @(negedge clk);
    regWe = 1'b0; auxEvt = 1'b0;
    chkPend("R7 set wins over ack", 3'b011);
    wr(3'd3, 16'h0003);
    check(irqOut == 1'b0, "R9 irq clear after full ack", irqOut, 0);
  endtask

  task automatic tPal();
    wr(3'd4, 16'h0001);
    palMode = 1'b1;
    lineNum = 9'd5;
    wr(3'd0, 16'h0030);
    wr(3'd2, 16'h0002);
    ticks(10);
    chkPend("R8 paused top border", 3'b000);
    lineNum = 9'd300;
    ticks(10);
    chkPend("R8 paused bottom border", 3'b000);
    lineNum = 9'd200;
    ticks(2);
    chkPend("R8 counts mid frame", 3'b000);
    ticks(1);
    chkPend("R8 expiry mid frame", 3'b010);
    wr(3'd3, 16'h0002);
    wr(3'd2, 16'h0002);
    lineNum = 9'd16;  ticks(1);
    lineNum = 9'd295; ticks(1);
    lineNum = 9'd296; ticks(5);
    lineNum = 9'd15;  ticks(5);
    chkPend("R8 edge lines 15 and 296 paused", 3'b000);
    lineNum = 9'd16;  ticks(1);
    chkPend("R8 edge lines 16 and 295 count", 3'b010);
    wr(3'd3, 16'h0002);
    palMode = 1'b0;
    lineNum = 9'd5;
    wr(3'd2, 16'h0001);
    ticks(2);
    chkPend("R8 no pause at 60Hz", 3'b010);
    wr(3'd3, 16'h0002);
    wr(3'd4, 16'h0000);
    palMode = 1'b1;
    wr(3'd2, 16'h0001);
    ticks(2);
    chkPend("R8 no pause with stop clear", 3'b010);
    wr(3'd3, 16'h0002);
    palMode = 1'b0;
  endtask

  task automatic tHighHalf();
    lineNum = 9'd100;
    wr(3'd1, 16'h0001);
    wr(3'd2, 16'h0000);
    ticks(65536);
    chkPend("R2 upper half in count", 3'b000);
    ticks(1);
    chkPend("R2 expiry at 65536+1 ticks", 3'b010);
    wr(3'd3, 16'h0002);
  endtask

  task automatic tStatus();
    lineNum = 9'd300; palMode = 1'b0;
    @(negedge clk);
    check(statusWord == 16'h9600, "R10 status 60Hz", statusWord, 16'h9600);
    palMode = 1'b1;
    @(negedge clk);
    check(statusWord == 16'h9608, "R10 status 50Hz", statusWord, 16'h9608);
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tOneShot();
    tDisable();
    tRepeat();
    tBlank();
    tAckBits();
    tPal();
    tHighHalf();
    tStatus();
    finished = 1'b1;
    finish();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish();
    end
  end

endmodule